// File: doc/BRIEF.md
# Lost Sample Repair Stage

This block sits in a sampled-value receive path, after the stage that lines up samples from several sources by sample number and before the resampler. One aligned slot arrives per strobe, carrying a sample word and three health bits: present (it arrived before the alignment deadline), quality good, and clock-synchronised. A slot with any health bit low is treated as lost. The block never stalls or blanks the stream. Every slot comes out, and each lost one is replaced by a value chosen by a mode input.

There are four modes: force to zero, repeat the previous output, take the first usable value after the gap, or a cubic estimate through two usable samples on each side of the gap. To see past a gap, every slot is held for a fixed delay of `MAX_RUN + 3` strobes, which is 8 at the default run limit of 5. A run of lost slots longer than the limit is too wide to estimate. It is filled with zeros and sets a sticky overflow flag. A saturating counter totals the replaced slots.

The cubic estimate for a slot at offset t inside a gap of length L (gap positions 0..L-1) uses nodes at -2, -1, L and L+1. With C = (L+1)(L+2)(L+3), the sum of the four Lagrange terms scaled by C is divided by C and truncated toward zero. The result is then clamped to the signed range of the sample word.

Top module: `lost_sample_repair`

## Requirements
- R1: A slot is lost when `slot_present` is 0, `slot_qual_ok` is 0, or `slot_synced` is 0; any one of these alone makes the slot lost.
- R2: Each cycle with `slot_stb` high gives exactly one `rep_stb` pulse on the next cycle. With the strobe of slot k+8 (default run limit), that pulse carries slot k. The first 8 pulses after reset carry value 0 with `rep_subst` 0.
- R3: A usable slot leaves with its value unchanged and `rep_subst` 0. Every lost slot leaves with `rep_subst` 1.
- R4: In mode 0 (`fill_mode` = 2'd0), a lost slot in a run of at most 5 is output as 0.
- R5: In mode 1, a lost slot in a run of at most 5 repeats the previous output value.
- R6: In mode 2, a lost slot in a run of at most 5 takes the value of the first usable slot after its run.
- R7: In mode 3, a lost slot in a run of at most 5 takes the truncated cubic estimate defined above. For data that follow a cubic in the slot index, this estimate is exact.
- R8: In mode 3, the two nodes before a run are the outputs already emitted for those slots, including earlier estimates. If the second slot after the run is itself lost, the first slot after the run is used for both after-nodes.
- R9: In every mode, each slot of a run longer than 5 lost slots is output as 0. `gap_overflow` then goes to 1 and stays there until reset. A run of exactly 5 does not set it.
- R10: `subst_count` increases by one for each output with `rep_subst` 1 and stops at its all-ones value.
- R11: The sample word carried by a lost slot has no effect on any output.
- R12: After reset, `rep_stb`, `rep_val`, `rep_subst`, `gap_overflow` and `subst_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | One aligned slot is offered this cycle |
| slot_val | input | SAMPLE_W | Signed sample word of the slot |
| slot_present | input | 1 | Slot arrived before the deadline |
| slot_qual_ok | input | 1 | Slot quality is good |
| slot_synced | input | 1 | Source clock was synchronised |
| fill_mode | input | 2 | 0 zero, 1 hold, 2 next usable, 3 cubic |
| rep_stb | output | 1 | Repaired slot valid this cycle |
| rep_val | output | SAMPLE_W | Repaired signed sample word |
| rep_subst | output | 1 | This output replaces a lost slot |
| gap_overflow | output | 1 | Sticky: a run longer than the limit occurred |
| subst_count | output | CNT_W | Saturating total of replaced slots |

## Verification
The delicate cycle is the one in which a cubic estimate reads, as one of its nodes, a value the block itself estimated only a few strobes before. A second such cycle is one in which the counter is already saturated while another run overflows. The bench provokes the first with patterns of gap, one usable slot, gap, on a linear and a cubic sample sequence. It provokes the second with a stream of ninety lost slots. Every output is compared with a value the bench derives from the node definitions with its own Lagrange arithmetic, and the overflow flag and counter are compared with counts taken from the stream.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;

    // Replacement policy for a lost slot
    typedef enum logic [1:0] {
        FILL_ZERO  = 2'd0,
        FILL_HOLD  = 2'd1,
        FILL_NEXT  = 2'd2,
        FILL_CUBIC = 2'd3
    } fill_mode_e;

    // Extent of the lost run around the slot being emitted (run limit up to 7)
    typedef struct packed {
        logic [3:0] older;     // lost slots directly before
        logic [3:0] newer;     // lost slots directly after
        logic       overflow;  // slot is lost and the run exceeds the limit
    } gap_info_t;

    // Common scale of the cubic weights for a gap of length len
    function automatic int cubic_den(input int len);
        return (len + 1) * (len + 2) * (len + 3);
    endfunction

    // Weight of node k (nodes -2, -1, len, len+1) scaled by cubic_den(len),
    // evaluated at gap offset t
    function automatic int cubic_weight(input int k, input int len, input int t);
        case (k)
            0:       return -(len + 1) * (t + 1) * (t - len) * (t - len - 1);
            1:       return  (len + 3) * (t + 2) * (t - len) * (t - len - 1);
            2:       return -(len + 3) * (t + 2) * (t + 1) * (t - len - 1);
            default: return  (len + 1) * (t + 2) * (t + 1) * (t - len);
        endcase
    endfunction

endpackage

// File: rtl/lsr_window.sv
`timescale 1ns/1ps
module lsr_window #(
    parameter int W     = 16,
    parameter int DEPTH = 14,
    parameter int CTR   = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift,
    input  logic [W-1:0]              in_val,
    input  logic                      in_lost,
    input  logic [W-1:0]              rep_val,
    output logic [DEPTH-1:0][W-1:0]   win_val,
    output logic [DEPTH-1:0]          win_lost
);

    // Index 0 is the newest slot. Stages older than the emit point hold
    // repaired values, so the cubic and hold paths see emitted outputs.
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic [W-1:0] v_q;
        logic         l_q;
        logic [W-1:0] v_d;
        logic         l_d;

        if (i == 0) begin : g_head
            assign v_d = in_val;
            assign l_d = in_lost;
        end else if (i == CTR + 1) begin : g_repaired
            assign v_d = rep_val;
            assign l_d = win_lost[i-1];
        end else begin : g_plain
            assign v_d = win_val[i-1];
            assign l_d = win_lost[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= '0;
                l_q <= 1'b0;
            end else if (shift) begin
                v_q <= v_d;
                l_q <= l_d;
            end
        end

        assign win_val[i]  = v_q;
        assign win_lost[i] = l_q;
    end

endmodule

// File: rtl/lsr_gap_scan.sv
`timescale 1ns/1ps
module lsr_gap_scan
    import lsr_pkg::*;
#(
    parameter int MAX_RUN = 5
) (
    // Bit MAX_RUN is the slot being emitted; higher bits are older slots
    input  logic [2*MAX_RUN:0] lost_win,
    output gap_info_t          info
);

    logic older_run;
    logic newer_run;

    always_comb begin
        info      = '0;
        older_run = 1'b1;
        newer_run = 1'b1;
        for (int i = 1; i <= MAX_RUN; i++) begin
            if (older_run && lost_win[MAX_RUN + i])
                info.older = info.older + 4'd1;
            else
                older_run = 1'b0;
            if (newer_run && lost_win[MAX_RUN - i])
                info.newer = info.newer + 4'd1;
            else
                newer_run = 1'b0;
        end
        info.overflow = lost_win[MAX_RUN] &&
                        ((int'(info.older) + int'(info.newer) + 1) > MAX_RUN);
    end

endmodule

// File: rtl/lsr_cubic.sv
`timescale 1ns/1ps
module lsr_cubic
    import lsr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] p0,   // node -2
    input  logic signed [W-1:0] p1,   // node -1
    input  logic signed [W-1:0] p2,   // node len
    input  logic signed [W-1:0] p3,   // node len+1
    input  logic [3:0]          len,
    input  logic [3:0]          pos,
    output logic signed [W-1:0] est
);

    localparam longint MAXV = (longint'(1) <<< (W - 1)) - 64'sd1;
    localparam longint MINV = -MAXV - 64'sd1;

    int     l_i;
    int     t_i;
    longint acc;
    longint quot;

    always_comb begin
        l_i  = int'(len);
        t_i  = int'(pos);
        acc  = longint'(cubic_weight(0, l_i, t_i)) * longint'(p0)
             + longint'(cubic_weight(1, l_i, t_i)) * longint'(p1)
             + longint'(cubic_weight(2, l_i, t_i)) * longint'(p2)
             + longint'(cubic_weight(3, l_i, t_i)) * longint'(p3);
        quot = acc / longint'(cubic_den(l_i));   // truncates toward zero
        if (quot > MAXV)
            quot = MAXV;
        else if (quot < MINV)
            quot = MINV;
        est = quot[W-1:0];
    end

endmodule

// File: rtl/lost_sample_repair.sv
`timescale 1ns/1ps
module lost_sample_repair
    import lsr_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int MAX_RUN  = 5,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                slot_stb,
    input  logic [SAMPLE_W-1:0] slot_val,
    input  logic                slot_present,
    input  logic                slot_qual_ok,
    input  logic                slot_synced,
    input  logic [1:0]          fill_mode,
    output logic                rep_stb,
    output logic [SAMPLE_W-1:0] rep_val,
    output logic                rep_subst,
    output logic                gap_overflow,
    output logic [CNT_W-1:0]    subst_count
);

    localparam int LAT   = MAX_RUN + 3;
    localparam int CTR   = LAT - 1;
    localparam int DEPTH = LAT + MAX_RUN + 1;
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [DEPTH-1:0][SAMPLE_W-1:0] win_val;
    logic [DEPTH-1:0]               win_lost;
    logic                           in_lost;
    gap_info_t                      gi;
    fill_mode_e                     mode;

    logic [IDX_W-1:0]               a1_idx, a2_idx, b1_idx, b2_idx;
    logic signed [SAMPLE_W-1:0]     n_before2, n_before1, n_after1, n_after2;
    logic signed [SAMPLE_W-1:0]     cubic_est;
    logic [3:0]                     gap_len;
    logic [SAMPLE_W-1:0]            nxt_val;
    logic                           nxt_subst;

    assign in_lost = !(slot_present && slot_qual_ok && slot_synced);
    assign mode    = fill_mode_e'(fill_mode);

    lsr_window #(
        .W     (SAMPLE_W),
        .DEPTH (DEPTH),
        .CTR   (CTR)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .shift    (slot_stb),
        .in_val   (slot_val),
        .in_lost  (in_lost),
        .rep_val  (nxt_val),
        .win_val  (win_val),
        .win_lost (win_lost)
    );

    lsr_gap_scan #(
        .MAX_RUN (MAX_RUN)
    ) u_scan (
        .lost_win (win_lost[CTR+MAX_RUN:CTR-MAX_RUN]),
        .info     (gi)
    );

    // Node positions around the run containing the emit slot
    always_comb begin
        if (gi.overflow) begin
            a1_idx = IDX_W'(CTR);
            a2_idx = IDX_W'(CTR);
            b1_idx = IDX_W'(CTR);
            b2_idx = IDX_W'(CTR);
        end else begin
            a1_idx = IDX_W'(CTR - int'(gi.newer) - 1);
            a2_idx = IDX_W'(CTR - int'(gi.newer) - 2);
            b1_idx = IDX_W'(CTR + int'(gi.older) + 1);
            b2_idx = IDX_W'(CTR + int'(gi.older) + 2);
        end
        n_after1  = $signed(win_val[a1_idx]);
        n_after2  = win_lost[a2_idx] ? n_after1 : $signed(win_val[a2_idx]);
        n_before1 = $signed(win_val[b1_idx]);
        n_before2 = $signed(win_val[b2_idx]);
        gap_len   = gi.older + gi.newer + 4'd1;
    end

    lsr_cubic #(
        .W (SAMPLE_W)
    ) u_cubic (
        .p0  (n_before2),
        .p1  (n_before1),
        .p2  (n_after1),
        .p3  (n_after2),
        .len (gap_len),
        .pos (gi.older),
        .est (cubic_est)
    );

    // Replacement choice for the slot at the emit point
    always_comb begin
        nxt_subst = win_lost[CTR];
        nxt_val   = win_val[CTR];
        if (win_lost[CTR]) begin
            if (gi.overflow) begin
                nxt_val = '0;
            end else begin
                case (mode)
                    FILL_ZERO:  nxt_val = '0;
                    FILL_HOLD:  nxt_val = win_val[CTR+1];
                    FILL_NEXT:  nxt_val = n_after1;
                    default:    nxt_val = cubic_est;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_stb      <= 1'b0;
            rep_val      <= '0;
            rep_subst    <= 1'b0;
            gap_overflow <= 1'b0;
            subst_count  <= '0;
        end else begin
            rep_stb <= slot_stb;
            if (slot_stb) begin
                rep_val   <= nxt_val;
                rep_subst <= nxt_subst;
                if (gi.overflow)
                    gap_overflow <= 1'b1;
                if (nxt_subst && subst_count != CNT_MAX)
                    subst_count <= subst_count + 1'b1;
            end
        end
    end

    // R2
    stb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        slot_stb |=> rep_stb);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_stb |=> !rep_stb);

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        slot_stb && !win_lost[CTR] |=> !rep_subst && rep_val == $past(win_val[CTR]));

    // R4
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        slot_stb && win_lost[CTR] && mode == FILL_ZERO |=> rep_subst && rep_val == '0);

    // R5
    hold_fill_chk: assert property (@(posedge clk) disable iff (rst)
        slot_stb && win_lost[CTR] && !gi.overflow && mode == FILL_HOLD
        |=> rep_subst && rep_val == $past(rep_val));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        gap_overflow |=> gap_overflow);

    // R9
    ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gap_overflow) |-> rep_subst && rep_val == '0);

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        rep_stb && rep_subst && $past(subst_count) != CNT_MAX
        |-> subst_count == $past(subst_count) + 1'b1);

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rep_stb |-> $stable(subst_count));

endmodule

// File: tb/sim_lost_sample_repair.sv
`timescale 1ns/1ps
module sim_lost_sample_repair;

    localparam int W    = 24;
    localparam int MR   = 5;
    localparam int CW   = 6;
    localparam int NS   = 100;
    localparam int LATN = MR + 3;
    localparam longint VMAX = (longint'(1) <<< (W - 1)) - 1;
    localparam longint VMIN = -VMAX - 1;
    localparam longint CMAX = (longint'(1) <<< CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slot_stb = 1'b0;
    logic [W-1:0]  slot_val = '0;
    logic          slot_present = 1'b1;
    logic          slot_qual_ok = 1'b1;
    logic          slot_synced = 1'b1;
    logic [1:0]    fill_mode = 2'd0;
    logic          rep_stb;
    logic [W-1:0]  rep_val;
    logic          rep_subst;
    logic          gap_overflow;
    logic [CW-1:0] subst_count;

    always #2.5 clk = ~clk;

    lost_sample_repair #(
        .SAMPLE_W (W),
        .MAX_RUN  (MR),
        .CNT_W    (CW)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .slot_stb     (slot_stb),
        .slot_val     (slot_val),
        .slot_present (slot_present),
        .slot_qual_ok (slot_qual_ok),
        .slot_synced  (slot_synced),
        .fill_mode    (fill_mode),
        .rep_stb      (rep_stb),
        .rep_val      (rep_val),
        .rep_subst    (rep_subst),
        .gap_overflow (gap_overflow),
        .subst_count  (subst_count)
    );

    int n_checks = 0;
    int n_fail   = 0;

    longint sv [NS];
    bit     lf [NS];
    longint rep_m [NS];
    bit     sub_m [NS];
    string  tag_m [NS];
    bit     ovf_m;
    longint cnt_m;
    bit     mon_on = 1'b0;
    int     out_idx = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint poly(input int k, input int kind);
        longint u;
        u = longint'(k - 50);
        if (kind == 3) return 40 + 12 * longint'(k);   // linear sequence
        return u * u * u + 2 * u * u - 5 * u + 7;
    endfunction

    function automatic void mark(input int a, input int n);
        for (int i = a; i < a + n; i++) lf[i] = 1'b1;
    endfunction

    // kind 0: runs of 1..7 plus gap/usable/gap patterns; 1: long lost run;
    // 2: one run of exactly 5; 3: linear data with gap/usable/gap patterns
    function automatic void build(input int kind);
        int p;
        for (int k = 0; k < NS; k++) lf[k] = 1'b0;
        if (kind == 0) begin
            p = 10;
            for (int len = 1; len <= 7; len++) begin
                mark(p, len);
                p = p + len + 4;
            end
            mark(p, 1); mark(p + 2, 1);
            p = p + 6;
            mark(p, 2); mark(p + 3, 1);
        end else if (kind == 1) begin
            mark(0, 90);
        end else if (kind == 2) begin
            mark(20, 5);
        end else begin
            mark(12, 1); mark(14, 1);
            mark(30, 3); mark(34, 2);
            mark(50, 5); mark(56, 1);
        end
        for (int k = 0; k < NS; k++)
            sv[k] = lf[k] ? longint'(24'sh5A5A5 + k) : poly(k, kind);   // R11 junk in lost slots
    endfunction

    function automatic longint get_rep(input int i);
        return (i < 0) ? 0 : rep_m[i];
    endfunction

    function automatic longint lagrange(input longint p0, input longint p1,
                                        input longint p2, input longint p3,
                                        input int len, input int t);
        longint xs [4];
        longint ps [4];
        longint acc, num, den, c, q;
        xs[0] = -2; xs[1] = -1; xs[2] = len; xs[3] = len + 1;
        ps[0] = p0; ps[1] = p1; ps[2] = p2; ps[3] = p3;
        c = longint'((len + 1) * (len + 2) * (len + 3));
        acc = 0;
        for (int i = 0; i < 4; i++) begin
            num = 1; den = 1;
            for (int j = 0; j < 4; j++) begin
                if (j != i) begin
                    num = num * (longint'(t) - xs[j]);
                    den = den * (xs[i] - xs[j]);
                end
            end
            acc = acc + ps[i] * num * (c / den);
        end
        q = acc / c;
        if (q > VMAX) q = VMAX;
        if (q < VMIN) q = VMIN;
        return q;
    endfunction

    function automatic void model(input int mode);
        int o, n, len;
        longint p3;
        ovf_m = 1'b0;
        cnt_m = 0;
        for (int k = 0; k < NS; k++) begin
            if (!lf[k]) begin
                rep_m[k] = sv[k];
                sub_m[k] = 1'b0;
                tag_m[k] = "R3";
            end else begin
                sub_m[k] = 1'b1;
                o = 0;
                while (o < MR && k - o - 1 >= 0 && lf[k-o-1]) o++;
                n = 0;
                while (n < MR && k + n + 1 < NS && lf[k+n+1]) n++;
                len = o + 1 + n;
                if (len > MR) begin
                    rep_m[k] = 0;
                    tag_m[k] = "R1 R9 R11";
                    if (k < NS - LATN) ovf_m = 1'b1;
                end else begin
                    case (mode)
                        0: begin rep_m[k] = 0;             tag_m[k] = "R1 R4 R11"; end
                        1: begin rep_m[k] = get_rep(k-1);  tag_m[k] = "R1 R5 R11"; end
                        2: begin rep_m[k] = sv[k+n+1];     tag_m[k] = "R1 R6 R11"; end
                        default: begin
                            p3 = lf[k+n+2] ? sv[k+n+1] : sv[k+n+2];
                            rep_m[k] = lagrange(get_rep(k-o-2), get_rep(k-o-1),
                                                sv[k+n+1], p3, len, o);
                            if (lf[k+n+2] || (k - o - 2 >= 0 && lf[k-o-2]))
                                tag_m[k] = "R8 R11";
                            else
                                tag_m[k] = "R1 R7 R11";
                        end
                    endcase
                end
                if (k < NS - LATN) cnt_m++;
            end
        end
        if (cnt_m > CMAX) cnt_m = CMAX;
    endfunction

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (mon_on && rep_stb) begin
            if (out_idx < LATN) begin
                check(rep_val == '0 && !rep_subst, "R2 history",
                      longint'($signed(rep_val)), 0);
            end else if (out_idx < NS) begin
                check(longint'($signed(rep_val)) == rep_m[out_idx-LATN] &&
                      rep_subst == sub_m[out_idx-LATN],
                      tag_m[out_idx-LATN],
                      longint'($signed(rep_val)) * 2 + longint'(rep_subst),
                      rep_m[out_idx-LATN] * 2 + longint'(sub_m[out_idx-LATN]));
            end
            out_idx++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        slot_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!rep_stb && rep_val == '0 && !rep_subst && !gap_overflow && subst_count == '0,
              "R12 reset state", longint'(rep_val) + longint'(subst_count), 0);
    endtask

    task automatic drive_slot(input int k);
        @(negedge clk);
        slot_val     = sv[k][W-1:0];
        slot_present = !(lf[k] && (k % 3 == 0));   // R1 causes rotate
        slot_qual_ok = !(lf[k] && (k % 3 == 1));
        slot_synced  = !(lf[k] && (k % 3 == 2));
        slot_stb     = 1'b1;
        @(negedge clk);
        slot_stb     = 1'b0;
    endtask

    task automatic run_stream(input int kind, input int mode);
        do_reset();
        build(kind);
        model(mode);
        fill_mode = 2'(mode);
        out_idx = 0;
        mon_on = 1'b1;
        for (int k = 0; k < NS; k++) drive_slot(k);
        repeat (4) @(negedge clk);
        mon_on = 1'b0;
        check(out_idx == NS, "R2 one output per strobe", out_idx, NS);
        check(gap_overflow == ovf_m, "R9 overflow flag", gap_overflow, ovf_m);
        check(longint'(subst_count) == cnt_m, "R10 substitution count",
              longint'(subst_count), cnt_m);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", out_idx, NS);
        finish_run();
    end

    initial begin
        for (int m = 0; m < 4; m++) run_stream(0, m);
        run_stream(1, 3);   // saturating count with long overflow run
        run_stream(1, 1);
        run_stream(2, 3);   // run of exactly the limit
        run_stream(2, 2);
        run_stream(3, 3);   // estimates feeding later estimates
        run_stream(3, 1);
        finish_run();
    end

endmodule